// File: doc/BRIEF.md
# Serial Command and Data Receiver for a Dot-Matrix Display Controller

This block sits behind a write-only, three-wire synchronous serial link driven by a host: an active-low select, a serial clock, a data line and a command/data select. It shifts in bytes, most significant bit first. Each completed byte is either decoded as a command that updates the controller's configuration registers, or handed on as a display-memory write strobe carrying the byte.

The command set is split into two pages chosen by a page bit held in the function-set register. The function-set command and the no-op work on both pages. Page 0 holds the display mode and the X and Y pointer loads. Page 1 holds the temperature coefficient, the bias code and the operating-voltage code. The serial clock, select, data and command/data lines are synchronized into the system clock domain through matched synchronizer chains. The system clock must run at least four times the serial bit rate. Reset is active low and is applied on the system clock edge.

Top module: `lcd_serial_rx`

## Requirements
- R1: A byte is shifted in on eight rising serial-clock edges, most significant bit first. When the command/data line is high at the eighth edge, the block emits exactly one single-cycle `wr_stb` with that byte on `wr_byte`, and the configuration registers do not change.
- R2: While `ser_sel_n` is high, serial-clock edges are ignored and the bit count returns to the start. A byte cut short by raising the select writes nothing. The next transfer begins with bit 7.
- R3: If the select stays low after a byte completes, the next rising edge carries bit 7 of the following byte, so bytes can be sent back to back.
- R4: The command/data line is sampled only at the eighth edge of each byte, with 0 meaning command and 1 meaning data. Its level during the first seven bits has no effect.
- R5: Command 0010_0PVH (bits 7..3 = 00100) sets power-down = bit 2, vertical addressing = bit 1 and page = bit 0, on either page.
- R6: On page 0, 0000_1D0E sets the display mode to {D,E} (bit 2, bit 0). 0100_0yyy loads the Y pointer with bits 2..0 and pulses `y_load`. 1xxx_xxxx loads the X pointer with bits 6..0 and pulses `x_load`.
- R7: On page 1, 0000_01tt sets the temperature coefficient to bits 1..0. 0001_0bbb sets the bias code to bits 2..0. 1vvv_vvvv sets the operating-voltage code to bits 6..0.
- R8: Commands of one page have no effect on the other page. For example, a byte with bit 7 set loads X only on page 0 and the voltage code only on page 1.
- R9: Command 0x00 and every reserved pattern on either page leave all registers unchanged and pulse no strobe.
- R10: Reset forces power-down = 1 and every other register and pointer to 0. A byte in progress is discarded and nothing is written.
- R11: If the select is low when reset is released, the next eight rising edges form a fresh byte starting at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on `clk` |
| ser_clk | input | 1 | Serial clock from the host |
| ser_sel_n | input | 1 | Active-low transfer select |
| ser_din | input | 1 | Serial data, MSB first |
| ser_dc | input | 1 | Command (0) or data (1) select |
| wr_stb | output | 1 | One-cycle display-data write strobe |
| wr_byte | output | 8 | Data byte for the write |
| x_load | output | 1 | One-cycle pulse when the X pointer is loaded |
| y_load | output | 1 | One-cycle pulse when the Y pointer is loaded |
| pwr_down | output | 1 | Power-down flag |
| vert_mode | output | 1 | Vertical addressing direction flag |
| ext_page | output | 1 | Command page select |
| disp_mode | output | 2 | Display mode {D,E} |
| tcoef | output | 2 | Temperature coefficient code |
| bias | output | 3 | Bias code |
| vop | output | 7 | Operating-voltage code |
| x_ptr | output | 7 | X pointer |
| y_ptr | output | 3 | Y pointer |

## Verification
The bench builds the block with three synchronizer stages instead of the default two. This lengthens the path from a serial edge to a register update, so the check points must allow for that latency. Serial bits last eight system clocks, which keeps the clock-to-rate margin above the four-times minimum. With this timing, the bench can send back-to-back bytes, flip the command/data line within a byte, cut a byte short with the select, and apply a reset mid-byte while the select stays low.

// File: rtl/lcd_rx_pkg.sv
// Shared types for the serial command/data receiver.
// Assumes byte-wide commands with fixed field positions.
package lcd_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int XP_W   = 7;
    localparam int YP_W   = 3;
    localparam int VOP_W  = 7;
    localparam int BS_W   = 3;

    typedef struct packed {
        logic             pd;
        logic             v;
        logic             h;
        logic [1:0]       disp;
        logic [1:0]       tc;
        logic [BS_W-1:0]  bs;
        logic [VOP_W-1:0] vop;
        logic [XP_W-1:0]  x;
        logic [YP_W-1:0]  y;
    } ctrl_regs_t;

    localparam ctrl_regs_t REGS_RST = '{pd: 1'b1, default: '0};
endpackage

// File: rtl/lcd_rx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes inputs change slowly relative to clk; RST_VAL is the idle level.
module lcd_rx_sync #(
    parameter int       STAGES  = 2,
    parameter int       W       = 1,
    parameter logic     RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One flop stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= {W{RST_VAL}};
                else        chain[s] <= (s == 0) ? async_in : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lcd_rx_shift.sv
// Byte assembler: detects serial-clock rising edges, shifts MSB first,
// latches the command/data level with the last bit.
// Assumes all inputs are already synchronized to clk.
module lcd_rx_shift
    import lcd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sel_n_s,
    input  logic              din_s,
    input  logic              dc_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_dat,
    output logic              byte_dc
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic             sclk_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic             rise;

    assign rise = sclk_s & ~sclk_q;

    // Edge history, bit counting and byte completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_dat <= '0;
            byte_dc  <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            byte_vld <= 1'b0;
            if (sel_n_s) begin
                bit_cnt <= '0;
            end else if (rise) begin
                if (bit_cnt == LAST) begin
                    byte_vld <= 1'b1;
                    byte_dat <= {shreg, din_s};
                    byte_dc  <= dc_s;
                    bit_cnt  <= '0;
                end else begin
                    shreg   <= {shreg[BYTE_W-3:0], din_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcd_rx_decode.sv
// Command decoder: applies paged commands to the control registers and
// forwards data bytes as write strobes. Reserved patterns are dropped.
module lcd_rx_decode
    import lcd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              byte_dc,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              x_load,
    output logic              y_load,
    output ctrl_regs_t        regs
);
    // Register update and strobe generation per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs    <= REGS_RST;
            wr_stb  <= 1'b0;
            wr_byte <= '0;
            x_load  <= 1'b0;
            y_load  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            x_load <= 1'b0;
            y_load <= 1'b0;
            if (byte_vld) begin
                if (byte_dc) begin
                    wr_stb  <= 1'b1;
                    wr_byte <= byte_dat;
                end else if (byte_dat[7:3] == 5'b00100) begin
                    regs.pd <= byte_dat[2];
                    regs.v  <= byte_dat[1];
                    regs.h  <= byte_dat[0];
                end else if (!regs.h) begin
                    if (byte_dat[7]) begin
                        regs.x <= byte_dat[XP_W-1:0];
                        x_load <= 1'b1;
                    end else if (byte_dat[7:3] == 5'b01000) begin
                        regs.y <= byte_dat[YP_W-1:0];
                        y_load <= 1'b1;
                    end else if (byte_dat[7:3] == 5'b00001 && !byte_dat[1]) begin
                        regs.disp <= {byte_dat[2], byte_dat[0]};
                    end
                end else begin
                    if (byte_dat[7]) begin
                        regs.vop <= byte_dat[VOP_W-1:0];
                    end else if (byte_dat[7:2] == 6'b000001) begin
                        regs.tc <= byte_dat[1:0];
                    end else if (byte_dat[7:3] == 5'b00010) begin
                        regs.bs <= byte_dat[BS_W-1:0];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lcd_serial_rx.sv
// Top of the serial command/data receiver: synchronizers, byte assembler
// and paged command decoder. Assumes clk is at least 4x the serial bit rate.
module lcd_serial_rx
    import lcd_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sel_n,
    input  logic              ser_din,
    input  logic              ser_dc,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              x_load,
    output logic              y_load,
    output logic              pwr_down,
    output logic              vert_mode,
    output logic              ext_page,
    output logic [1:0]        disp_mode,
    output logic [1:0]        tcoef,
    output logic [BS_W-1:0]   bias,
    output logic [VOP_W-1:0]  vop,
    output logic [XP_W-1:0]   x_ptr,
    output logic [YP_W-1:0]   y_ptr
);
    logic [2:0]        lines_s;
    logic              sel_n_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_dat;
    logic              byte_dc;
    ctrl_regs_t        regs;

    lcd_rx_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(1'b0)) u_sync_lines (
        .clk(clk), .rst_n(rst_n),
        .async_in({ser_clk, ser_din, ser_dc}), .sync_out(lines_s)
    );

    lcd_rx_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b1)) u_sync_sel (
        .clk(clk), .rst_n(rst_n),
        .async_in(ser_sel_n), .sync_out(sel_n_s)
    );

    lcd_rx_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(lines_s[2]), .sel_n_s(sel_n_s), .din_s(lines_s[1]), .dc_s(lines_s[0]),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_dc(byte_dc)
    );

    lcd_rx_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .byte_dc(byte_dc),
        .wr_stb(wr_stb), .wr_byte(wr_byte), .x_load(x_load), .y_load(y_load),
        .regs(regs)
    );

    assign pwr_down  = regs.pd;
    assign vert_mode = regs.v;
    assign ext_page  = regs.h;
    assign disp_mode = regs.disp;
    assign tcoef     = regs.tc;
    assign bias      = regs.bs;
    assign vop       = regs.vop;
    assign x_ptr     = regs.x;
    assign y_ptr     = regs.y;
endmodule

// File: rtl/lcd_serial_rx_chk.sv
// Property checker for lcd_serial_rx, attached by bind.
// Assumes the port timing of the top module.
module lcd_serial_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stb,
    input logic       x_load,
    input logic       y_load,
    input logic       pwr_down,
    input logic       ext_page,
    input logic [1:0] disp_mode,
    input logic [6:0] vop,
    input logic [6:0] x_ptr,
    input logic [2:0] y_ptr
);
    logic rst_q = 1'b0;

    // Remember that reset was low on the previous edge.
    always_ff @(posedge clk) rst_q <= !rst_n;

    // R10: one edge after reset, the register file holds its reset values.
    always_ff @(posedge clk) begin
        if (rst_q) assert_reset_vals_R10: assert (pwr_down && x_ptr == 7'd0 && y_ptr == 3'd0
                                                 && vop == 7'd0 && disp_mode == 2'd0 && !ext_page);
    end

    assert_wr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !(x_load || y_load));

    assert_xload_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        x_load |-> !ext_page);

    assert_vop_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vop) |-> $past(ext_page));

    assert_disp_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_mode) |-> !$past(ext_page));
endmodule

bind lcd_serial_rx lcd_serial_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .x_load(x_load), .y_load(y_load),
    .pwr_down(pwr_down), .ext_page(ext_page), .disp_mode(disp_mode),
    .vop(vop), .x_ptr(x_ptr), .y_ptr(y_ptr)
);

// File: tb/sim_lcd_serial_rx.sv
module sim_lcd_serial_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_sel_n = 1'b1;
    logic       ser_din = 1'b0;
    logic       ser_dc = 1'b0;
    logic       wr_stb, x_load, y_load, pwr_down, vert_mode, ext_page;
    logic [7:0] wr_byte;
    logic [1:0] disp_mode, tcoef;
    logic [2:0] bias, y_ptr;
    logic [6:0] vop, x_ptr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int wr_cnt = 0, x_cnt = 0, y_cnt = 0;
    logic [7:0] last_b = 8'h00, prev_b = 8'h00;

    always #4 clk = ~clk;

    lcd_serial_rx #(.SYNC_STAGES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .ser_dc(ser_dc), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .x_load(x_load), .y_load(y_load), .pwr_down(pwr_down), .vert_mode(vert_mode),
        .ext_page(ext_page), .disp_mode(disp_mode), .tcoef(tcoef), .bias(bias),
        .vop(vop), .x_ptr(x_ptr), .y_ptr(y_ptr)
    );

    // Strobe monitor at the ports.
    always @(posedge clk) begin
        if (wr_stb) begin
            wr_cnt <= wr_cnt + 1;
            prev_b <= last_b;
            last_b <= wr_byte;
        end
        if (x_load) x_cnt <= x_cnt + 1;
        if (y_load) y_cnt <= y_cnt + 1;
    end

    // Snapshot order {pd,v,h,disp[1:0],tc[1:0],bs[2:0],vop[6:0],x[6:0],y[2:0]}.
    function automatic logic [26:0] snap();
        return {pwr_down, vert_mode, ext_page, disp_mode, tcoef, bias, vop, x_ptr, y_ptr};
    endfunction

    localparam logic [26:0] SNAP_RST = {1'b1, 26'd0};

    // Vector: {dc, byte, expected snapshot, expect write}
    localparam int NV = 21;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 8'h21, 1'b0,1'b0,1'b1, 2'd0, 2'd0, 3'd0, 7'h00, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h90, 1'b0,1'b0,1'b1, 2'd0, 2'd0, 3'd0, 7'h10, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h06, 1'b0,1'b0,1'b1, 2'd0, 2'd2, 3'd0, 7'h10, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h13, 1'b0,1'b0,1'b1, 2'd0, 2'd2, 3'd3, 7'h10, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'hC5, 1'b0,1'b0,1'b1, 2'd0, 2'd2, 3'd3, 7'h45, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h0C, 1'b0,1'b0,1'b1, 2'd0, 2'd2, 3'd3, 7'h45, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h42, 1'b0,1'b0,1'b1, 2'd0, 2'd2, 3'd3, 7'h45, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h22, 1'b0,1'b1,1'b0, 2'd0, 2'd2, 3'd3, 7'h45, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h0D, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h00, 3'd0, 1'b0},
        {1'b0, 8'h43, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h00, 3'd3, 1'b0},
        {1'b0, 8'hD3, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h53, 3'd3, 1'b0},
        {1'b0, 8'h05, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h53, 3'd3, 1'b0},
        {1'b0, 8'h93, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b0},
        {1'b0, 8'h00, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b0},
        {1'b0, 8'h0E, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b0},
        {1'b0, 8'h30, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b0},
        {1'b1, 8'hA5, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b1},
        {1'b1, 8'h3C, 1'b0,1'b1,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b1},
        {1'b0, 8'h23, 1'b0,1'b1,1'b1, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b0},
        {1'b1, 8'h7E, 1'b0,1'b1,1'b1, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b1},
        {1'b0, 8'h20, 1'b0,1'b0,1'b0, 2'd3, 2'd2, 3'd3, 7'h45, 7'h13, 3'd3, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits of b MSB first; dc_early on leading bits, dc_last on the eighth.
    task automatic send_bits(input logic [7:0] b, input logic dc_early,
                             input logic dc_last, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ser_din = b[7-i];
            ser_dc  = (i == 7) ? dc_last : dc_early;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic dc, input logic [7:0] b);
        ser_sel_n = 1'b0;
        wait_clk(4);
        send_bits(b, dc, dc, 8);
        wait_clk(2);
        ser_sel_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    initial begin
        int w0;
        logic [26:0] s0;
        wait_clk(5);
        // R10: reset state
        check("R10 reset snapshot", 32'(snap()), 32'(SNAP_RST));
        check("R10 no strobe in reset", 32'(wr_stb | x_load | y_load), 32'd0);
        rst_n = 1'b1;
        wait_clk(5);

        // Vector table: R1 R5 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            w0 = wr_cnt;
            send_byte(VEC[k][36], VEC[k][35:28]);
            check($sformatf("R5/R6/R7/R8/R9 vector %0d regs", k), 32'(snap()), 32'(VEC[k][27:1]));
            check($sformatf("R1 vector %0d write count", k), wr_cnt - w0, 32'(VEC[k][0]));
            if (VEC[k][0]) check($sformatf("R1 vector %0d byte", k), 32'(last_b), 32'(VEC[k][35:28]));
        end
        check("R6 x_load pulses", x_cnt, 32'd2);
        check("R6 y_load pulses", y_cnt, 32'd1);

        // R2: clocks ignored while select high
        s0 = snap(); w0 = wr_cnt;
        send_bits(8'hFF, 1'b1, 1'b1, 8);
        wait_clk(10);
        check("R2 no write with select high", wr_cnt - w0, 32'd0);
        check("R2 regs unchanged with select high", 32'(snap()), 32'(s0));
        // R2: partial byte aborted by select, then fresh byte
        ser_sel_n = 1'b0; wait_clk(4);
        send_bits(8'hFF, 1'b0, 1'b0, 3);
        ser_sel_n = 1'b1; wait_clk(6);
        send_byte(1'b1, 8'h5A);
        check("R2 one write after abort", wr_cnt - w0, 32'd1);
        check("R2 realigned byte", 32'(last_b), 32'h5A);

        // R3: back-to-back bytes
        w0 = wr_cnt;
        ser_sel_n = 1'b0; wait_clk(4);
        send_bits(8'h11, 1'b1, 1'b1, 8);
        send_bits(8'h22, 1'b1, 1'b1, 8);
        wait_clk(2); ser_sel_n = 1'b1; wait_clk(10);
        check("R3 two writes", wr_cnt - w0, 32'd2);
        check("R3 first byte", 32'(prev_b), 32'h11);
        check("R3 second byte", 32'(last_b), 32'h22);

        // R4: dc only counts on the eighth bit
        w0 = wr_cnt;
        ser_sel_n = 1'b0; wait_clk(4);
        send_bits(8'hC0, 1'b1, 1'b0, 8);
        wait_clk(2); ser_sel_n = 1'b1; wait_clk(10);
        check("R4 command despite early dc high", 32'(x_ptr), 32'h40);
        check("R4 no write for command", wr_cnt - w0, 32'd0);
        s0 = snap();
        ser_sel_n = 1'b0; wait_clk(4);
        send_bits(8'h21, 1'b0, 1'b1, 8);
        wait_clk(2); ser_sel_n = 1'b1; wait_clk(10);
        check("R4 data despite early dc low", wr_cnt - w0, 32'd1);
        check("R4 data byte", 32'(last_b), 32'h21);
        check("R4 regs unchanged by data", 32'(snap()), 32'(s0));

        // R10 and R11: reset mid-byte with select held low
        w0 = wr_cnt;
        ser_sel_n = 1'b0; wait_clk(4);
        send_bits(8'hFF, 1'b1, 1'b1, 4);
        rst_n = 1'b0; wait_clk(3);
        check("R10 reset snapshot mid-byte", 32'(snap()), 32'(SNAP_RST));
        rst_n = 1'b1; wait_clk(6);
        send_bits(8'h21, 1'b0, 1'b0, 8);
        wait_clk(10);
        check("R10 partial byte not written", wr_cnt - w0, 32'd0);
        check("R11 fresh byte after reset", 32'(snap()), 32'({1'b0, 1'b0, 1'b1, 24'd0}));
        ser_sel_n = 1'b1; wait_clk(4);

        finish_run();
    end
endmodule